// File: doc/BRIEF.md
# Multi-Unit Thread Group Scheduler

This block keeps a pool of resident thread groups and each cycle sends their next instructions to three execution pipes: fused multiply-add (FMA), conversion (CVT) and special function (SFU). The threads of a group run in lockstep, so the scheduler only tracks whole groups. It does not track lanes. The lane count is 4, 8 or 16, and that choice has no effect on scheduling. Each group records which pipe its next instruction needs. A pipe that is free takes one eligible group for that pipe. In one cycle up to three different groups can start together, one on each pipe.

Each issue holds its pipe for a fixed slot of four cycles. While the instruction is in flight the group cannot be picked again. A group that waits on memory or on another dependency is suspended by a stall pulse, and the other groups keep the pipes busy. A wake pulse makes the group eligible again. Groups enter through a launch port, which takes the lowest free entry and reports its index. They leave through a retire port. Each pipe keeps its own round-robin order over the pool.

Top module: `tg_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `iss_valid` is 0, `launch_ready` is 1 and `launch_id` is 0.
- R2: A launch goes to the lowest-indexed free entry, and that index is shown on `launch_id` in the cycle of the launch. When every entry is occupied, `launch_ready` is 0 and a launch request changes nothing.
- R3: A group issues only to the pipe that matches its next-unit code: 0 is FMA (issue lane 0), 1 is CVT (lane 1), 2 is SFU (lane 2) and 3 means no pipe, so the group never issues. The launch sets the code. An update pulse replaces it, and the new code applies from the next cycle.
- R4: Up to three groups can issue in the same cycle, one on each pipe. The same group never appears on two lanes at once.
- R5: If a pipe issues in cycle t, it issues nothing in cycles t+1 to t+3. It may issue again in cycle t+4.
- R6: A group issued in cycle t cannot be picked by any pipe before cycle t+4. From cycle t+4 it can be picked again.
- R7: After a stall pulse for a group in cycle t, that group is not issued from cycle t+1 until it is woken. If a stall arrives in the same cycle as a wake or launch of that group, the stall wins.
- R8: After a wake pulse in cycle t, the group can be issued from cycle t+1.
- R9: Each pipe picks the first eligible group after the one it issued last, wrapping at the end of the pool. After reset each pipe starts its search at entry 0.
- R10: A retired group is never issued again unless it is launched again. A retire must name a group that is not in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Request to allocate a new group |
| launch_unit | input | 2 | Next-unit code of the new group |
| launch_ready | output | 1 | At least one pool entry is free |
| launch_id | output | $clog2(NG) | Entry that a launch in this cycle would take |
| upd_valid | input | 1 | Replace a group's next-unit code |
| upd_id | input | $clog2(NG) | Group to update |
| upd_unit | input | 2 | New next-unit code |
| stall_valid | input | 1 | Suspend a group |
| stall_id | input | $clog2(NG) | Group to suspend |
| wake_valid | input | 1 | Resume a suspended group |
| wake_id | input | $clog2(NG) | Group to resume |
| retire_valid | input | 1 | Free a group's entry |
| retire_id | input | $clog2(NG) | Group to free |
| iss_valid | output | 3 | Per-pipe issue strobe (bit 0 FMA, 1 CVT, 2 SFU) |
| iss_id | output | 3*$clog2(NG) | Per-pipe issued group, pipe u at bits [u*GW +: GW] |

## Verification
The assertions check three things on every cycle. No pipe starts again within its slot. No group is placed on two lanes at once. A group that was just stalled or retired is not issued on the next cycle. The bench's scenarios cover what a property cannot show here. These are the round-robin order of each pipe, the choice of free entry at launch, the effect of updating a next-unit code, and the full-pool case. They also include three groups that become eligible in the same cycle by three different routes (a launch, a wake and an update) and issue together, then start again exactly when their slots end. A cycle-by-cycle reference model in the bench compares every output under random traffic.

// File: rtl/tg_sched_pkg.sv
// Shared constants and types for the thread group scheduler.
// Assumes exactly three pipe kinds; the unit code doubles as the lane index.
package tg_sched_pkg;
    localparam int NUM_UNITS = 3;

    typedef enum logic [1:0] {
        UNIT_FMA  = 2'd0,
        UNIT_CVT  = 2'd1,
        UNIT_SFU  = 2'd2,
        UNIT_NONE = 2'd3
    } unit_e;

    // Per-entry state of one resident group.
    typedef struct packed {
        logic       live;   // entry allocated
        logic       susp;   // parked on a dependency
        logic       fly;    // instruction in flight on some pipe
        logic [1:0] unit;   // next-unit code
    } grp_t;
endpackage

// File: rtl/tg_rr_pick.sv
// Round-robin picker: returns the first requester after index `last`,
// wrapping at N. Purely combinational; assumes last < N.
module tg_rr_pick #(
    parameter int N = 32,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] last,
    output logic         found,
    output logic [W-1:0] id
);
    // Scan from the farthest offset down so the nearest requester wins.
    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int k = N; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (req[idx]) begin
                found = 1'b1;
                id    = W'(idx);
            end
        end
    end
endmodule

// File: rtl/tg_unit_slot.sv
// Occupancy tracker for one pipe: a start loads SLOT-1 and the counter runs
// down to zero; `done` marks the last busy cycle. Assumes SLOT >= 2 and no
// start while busy.
module tg_unit_slot #(
    parameter int SLOT = 4,
    parameter int GW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [GW-1:0] start_id,
    output logic          busy,
    output logic          done,
    output logic [GW-1:0] owner
);
    localparam int CW = $clog2(SLOT);
    localparam logic [CW-1:0] LOAD = CW'(SLOT - 1);

    logic [CW-1:0] cnt_q;

    // Load the slot on start, otherwise count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            owner <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
            owner <= start_id;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/tg_sched.sv
// Thread group scheduler top. Holds NG group entries and issues up to one
// group per pipe per cycle; each issue holds its pipe SLOT cycles. Assumes
// retire names a group not in flight. Issue outputs depend only on state.
module tg_sched
    import tg_sched_pkg::*;
#(
    parameter int NG   = 32,
    parameter int SLOT = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            launch_valid,
    input  logic [1:0]                      launch_unit,
    output logic                            launch_ready,
    output logic [$clog2(NG)-1:0]           launch_id,
    input  logic                            upd_valid,
    input  logic [$clog2(NG)-1:0]           upd_id,
    input  logic [1:0]                      upd_unit,
    input  logic                            stall_valid,
    input  logic [$clog2(NG)-1:0]           stall_id,
    input  logic                            wake_valid,
    input  logic [$clog2(NG)-1:0]           wake_id,
    input  logic                            retire_valid,
    input  logic [$clog2(NG)-1:0]           retire_id,
    output logic [NUM_UNITS-1:0]            iss_valid,
    output logic [NUM_UNITS*$clog2(NG)-1:0] iss_id
);
    localparam int GW = $clog2(NG);

    grp_t                          grp [NG];
    logic [NUM_UNITS-1:0][NG-1:0]  elig;
    logic [NUM_UNITS-1:0]          pick_ok, unit_busy, unit_done;
    logic [GW-1:0]                 pick_id  [NUM_UNITS];
    logic [GW-1:0]                 owner_id [NUM_UNITS];
    logic [GW-1:0]                 last_q   [NUM_UNITS];
    logic [NG-1:0]                 issue_hit, done_hit;

    // Eligibility per pipe: live, awake, idle, and needs that pipe.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++)
            for (int g = 0; g < NG; g++)
                elig[u][g] = grp[g].live && !grp[g].susp && !grp[g].fly &&
                             (grp[g].unit == 2'(u));
    end

    // Lowest free entry for launch.
    always_comb begin
        launch_ready = 1'b0;
        launch_id    = '0;
        for (int g = NG - 1; g >= 0; g--)
            if (!grp[g].live) begin
                launch_ready = 1'b1;
                launch_id    = GW'(g);
            end
    end

    // One picker and one slot tracker per pipe.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        tg_rr_pick #(.N(NG), .W(GW)) u_pick (
            .req   (elig[u]),
            .last  (last_q[u]),
            .found (pick_ok[u]),
            .id    (pick_id[u])
        );

        assign iss_valid[u]          = pick_ok[u] && !unit_busy[u];
        assign iss_id[u*GW +: GW]    = pick_id[u];

        tg_unit_slot #(.SLOT(SLOT), .GW(GW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (iss_valid[u]),
            .start_id (pick_id[u]),
            .busy     (unit_busy[u]),
            .done     (unit_done[u]),
            .owner    (owner_id[u])
        );

        // Remember the last group this pipe issued for round-robin.
        always_ff @(posedge clk) begin
            if (!rst_n)            last_q[u] <= GW'(NG - 1);
            else if (iss_valid[u]) last_q[u] <= pick_id[u];
        end
    end

    // Per-group issue and completion flags gathered from all pipes.
    always_comb begin
        issue_hit = '0;
        done_hit  = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (iss_valid[u]) issue_hit[pick_id[u]]  = 1'b1;
            if (unit_done[u]) done_hit[owner_id[u]]  = 1'b1;
        end
    end

    // Group state update; later statements take precedence (stall last).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) grp[g] <= '0;
        end else begin
            for (int g = 0; g < NG; g++) begin
                if (done_hit[g])  grp[g].fly <= 1'b0;
                if (issue_hit[g]) grp[g].fly <= 1'b1;
                if (upd_valid && upd_id == GW'(g)) grp[g].unit <= upd_unit;
                if (wake_valid && wake_id == GW'(g)) grp[g].susp <= 1'b0;
                if (retire_valid && retire_id == GW'(g)) begin
                    grp[g].live <= 1'b0;
                    grp[g].susp <= 1'b0;
                    grp[g].fly  <= 1'b0;
                end
                if (launch_valid && launch_ready && launch_id == GW'(g)) begin
                    grp[g].live <= 1'b1;
                    grp[g].unit <= launch_unit;
                    grp[g].susp <= 1'b0;
                    grp[g].fly  <= 1'b0;
                end
                if (stall_valid && stall_id == GW'(g)) grp[g].susp <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tg_sched_chk.sv
// Property checker for tg_sched, bound to every instance. Watches only
// ports; a per-pipe counter measures the cycles since its last issue.
module tg_sched_chk #(
    parameter int NG   = 32,
    parameter int SLOT = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    stall_valid,
    input logic [$clog2(NG)-1:0]   stall_id,
    input logic                    retire_valid,
    input logic [$clog2(NG)-1:0]   retire_id,
    input logic [2:0]              iss_valid,
    input logic [3*$clog2(NG)-1:0] iss_id
);
    localparam int GW = $clog2(NG);

    for (genvar u = 0; u < 3; u++) begin : g_u
        int since;

        // Cycles since this pipe last issued, saturating at SLOT.
        always_ff @(posedge clk) begin
            if (!rst_n)             since <= SLOT;
            else if (iss_valid[u])  since <= 1;
            else if (since < SLOT)  since <= since + 1;
        end

        p_slot_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[u] |-> since >= SLOT);

        p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
            stall_valid |=> !(iss_valid[u] && iss_id[u*GW +: GW] == $past(stall_id)));

        p_retired_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            retire_valid |=> !(iss_valid[u] && iss_id[u*GW +: GW] == $past(retire_id)));
    end

    p_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid[0] && iss_valid[1] && iss_id[0 +: GW] == iss_id[GW +: GW]) &&
        !(iss_valid[0] && iss_valid[2] && iss_id[0 +: GW] == iss_id[2*GW +: GW]) &&
        !(iss_valid[1] && iss_valid[2] && iss_id[GW +: GW] == iss_id[2*GW +: GW]));
endmodule

bind tg_sched tg_sched_chk #(.NG(NG), .SLOT(SLOT)) u_tg_sched_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall_valid  (stall_valid),
    .stall_id     (stall_id),
    .retire_valid (retire_valid),
    .retire_id    (retire_id),
    .iss_valid    (iss_valid),
    .iss_id       (iss_id)
);

// File: tb/tg_sched_bench.sv
module tg_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NG   = 32;
    localparam int SLOT = 4;
    localparam int GW   = $clog2(NG);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            launch_valid = 0;
    logic [1:0]      launch_unit = 0;
    logic            launch_ready;
    logic [GW-1:0]   launch_id;
    logic            upd_valid = 0;
    logic [GW-1:0]   upd_id = 0;
    logic [1:0]      upd_unit = 0;
    logic            stall_valid = 0;
    logic [GW-1:0]   stall_id = 0;
    logic            wake_valid = 0;
    logic [GW-1:0]   wake_id = 0;
    logic            retire_valid = 0;
    logic [GW-1:0]   retire_id = 0;
    logic [2:0]      iss_valid;
    logic [3*GW-1:0] iss_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    tg_sched #(.NG(NG), .SLOT(SLOT)) u_tg_sched (.*);

    // Reference model state.
    bit       m_live [NG];
    bit       m_susp [NG];
    bit       m_fly  [NG];
    bit [1:0] m_unit [NG];
    int       m_cnt [3];
    int       m_own [3];
    int       m_last[3];
    bit       e_v   [3];
    int       e_id  [3];
    bit       e_rdy;
    int       e_fid;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    function automatic void model_reset();
        for (int g = 0; g < NG; g++) begin
            m_live[g] = 0; m_susp[g] = 0; m_fly[g] = 0; m_unit[g] = 0;
        end
        for (int u = 0; u < 3; u++) begin
            m_cnt[u] = 0; m_own[u] = 0; m_last[u] = NG - 1;
        end
    endfunction

    // Expected outputs for the current model state.
    function automatic void model_expect();
        for (int u = 0; u < 3; u++) begin
            e_v[u] = 0; e_id[u] = 0;
            if (m_cnt[u] == 0)
                for (int k = 1; k <= NG; k++) begin
                    int g;
                    g = (m_last[u] + k) % NG;
                    if (!e_v[u] && m_live[g] && !m_susp[g] && !m_fly[g] && m_unit[g] == 2'(u)) begin
                        e_v[u] = 1; e_id[u] = g;
                    end
                end
        end
        e_rdy = 0; e_fid = 0;
        for (int g = NG - 1; g >= 0; g--)
            if (!m_live[g]) begin e_rdy = 1; e_fid = g; end
    endfunction

    // Model next state from current inputs and expected issue.
    function automatic void model_step();
        for (int u = 0; u < 3; u++)
            if (m_cnt[u] == 1) m_fly[m_own[u]] = 0;
        for (int u = 0; u < 3; u++) begin
            if (e_v[u]) begin
                m_fly[e_id[u]] = 1; m_own[u] = e_id[u];
                m_cnt[u] = SLOT - 1; m_last[u] = e_id[u];
            end else if (m_cnt[u] != 0) m_cnt[u]--;
        end
        if (upd_valid)  m_unit[upd_id] = upd_unit;
        if (wake_valid) m_susp[wake_id] = 0;
        if (retire_valid) begin
            m_live[retire_id] = 0; m_susp[retire_id] = 0; m_fly[retire_id] = 0;
        end
        if (launch_valid && e_rdy) begin
            m_live[e_fid] = 1; m_unit[e_fid] = launch_unit;
            m_susp[e_fid] = 0; m_fly[e_fid] = 0;
        end
        if (stall_valid) m_susp[stall_id] = 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all outputs with the model (called at negedge).
    task automatic check_all(input string tag);
        model_expect();
        for (int u = 0; u < 3; u++) begin
            int a;
            a = iss_valid[u] ? int'(iss_id[u*GW +: GW]) : -1;
            chk(a == (e_v[u] ? e_id[u] : -1), $sformatf("%s issue lane %0d", tag, u), a,
                e_v[u] ? e_id[u] : -1);
        end
        chk(launch_ready == e_rdy && (!e_rdy || launch_id == GW'(e_fid)),
            {tag, " launch"}, {launch_ready, 8'(launch_id)}, {e_rdy, 8'(e_fid)});
    endtask

    task automatic clear_in();
        launch_valid = 0; upd_valid = 0; stall_valid = 0; wake_valid = 0; retire_valid = 0;
    endtask

    task automatic advance();
        model_step();
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held.
        chk(iss_valid == 3'b000, "R1 iss_valid in reset", iss_valid, 0);
        chk(launch_ready && launch_id == 0, "R1 launch in reset", {launch_ready, launch_id}, 1 << GW);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 after reset");

        // R4/R8/R3: three groups made eligible in one cycle by launch, wake, update.
        launch_valid = 1; launch_unit = 2'd0; stall_valid = 1; stall_id = 0;   // g0 FMA parked
        advance();
        check_all("R7 parked at launch");
        launch_valid = 1; launch_unit = 2'd3;                                   // g1 no pipe
        advance();
        check_all("R3 code 3 never issues");
        launch_valid = 1; launch_unit = 2'd2;                                   // g2 SFU
        wake_valid = 1; wake_id = 0;
        upd_valid = 1; upd_id = 1; upd_unit = 2'd1;
        advance();
        check_all("R8 R4 joint issue");
        chk(iss_valid == 3'b111, "R4 all three pipes start", iss_valid, 7);
        chk(iss_id == {GW'(2), GW'(1), GW'(0)}, "R3 lane per unit code", iss_id,
            {GW'(2), GW'(1), GW'(0)});
        for (int c = 1; c < SLOT; c++) begin
            advance();
            check_all("R5 slot hold");
            chk(iss_valid == 3'b000, "R5 no issue inside slot", iss_valid, 0);
        end
        advance();
        check_all("R6 reissue at slot end");
        chk(iss_valid == 3'b111, "R6 groups eligible at t+4", iss_valid, 7);

        // R9: several FMA groups rotate on the FMA pipe.
        for (int i = 0; i < 3; i++) begin
            launch_valid = 1; launch_unit = 2'd0;
            advance();
            check_all("R9 round robin");
        end
        for (int c = 0; c < 16; c++) begin
            advance();
            check_all("R9 round robin");
        end

        // Random traffic covering R3, R7, R8, R9, R10.
        for (int c = 0; c < 4000; c++) begin
            check_all("R3 R7 R8 R9 R10 random");
            if ($urandom_range(99) < 25) begin launch_valid = 1; launch_unit = 2'($urandom_range(3)); end
            if ($urandom_range(99) < 30) begin upd_valid = 1; upd_id = GW'($urandom_range(NG-1)); upd_unit = 2'($urandom_range(3)); end
            if ($urandom_range(99) < 10) begin stall_valid = 1; stall_id = GW'($urandom_range(NG-1)); end
            if ($urandom_range(99) < 25) begin wake_valid = 1; wake_id = GW'($urandom_range(NG-1)); end
            if ($urandom_range(99) < 20) begin
                int r;
                bit issuing;
                r = $urandom_range(NG-1);
                issuing = (e_v[0] && e_id[0] == r) || (e_v[1] && e_id[1] == r) || (e_v[2] && e_id[2] == r);
                if (m_live[r] && !m_fly[r] && !issuing) begin retire_valid = 1; retire_id = GW'(r); end
            end
            advance();
        end

        // R2: fill the pool, then a launch into a full pool changes nothing.
        for (int c = 0; c < NG + 2; c++) begin
            check_all("R2 fill");
            launch_valid = 1; launch_unit = 2'd3;
            advance();
        end
        check_all("R2 full pool");
        chk(launch_ready == 1'b0, "R2 full pool not ready", launch_ready, 0);
        launch_valid = 1; launch_unit = 2'd0;
        advance();
        check_all("R2 launch ignored when full");
        chk(launch_ready == 1'b0, "R2 still full", launch_ready, 0);
        // R10: retire one entry; it is reused by the next launch.
        retire_valid = 1; retire_id = GW'(5);
        advance();
        check_all("R10 retired frees entry");
        chk(launch_ready && launch_id == GW'(5), "R2 lowest free after retire", launch_id, 5);
        for (int c = 0; c < 8; c++) begin
            advance();
            check_all("R10 retired stays quiet");
        end
        finish_run();
    end
endmodule